// File: doc/BRIEF.md
# Layered Write-Permission Gate

This block decides, one request at a time, whether a write to a mixed volatile/nonvolatile device may go ahead. It keeps two enable latches: a general write-enable latch and a second latch that must also be set before the control register may be written. It also holds two block-lock bits and a synchronised copy of an external write-protect pin. Each request names a target class: volatile or nonvolatile wiper setting, memory array (with an address), or volatile or nonvolatile control-register bits. A separate latch command loads the two enable latches.

A request is accepted on any cycle in which `req_valid` is high. `req_ready` is tied high, so the block never applies back-pressure and the upstream decoder may present a new request every cycle. One cycle after acceptance the block answers with a one-cycle `grant_o` or `deny_o` pulse. For a granted nonvolatile target it also pulses `nv_start_o`, but only when the serial front end reported a well-formed frame (`frame_ok`) together with the request.

Encodings: `req_kind` 0 = latch command, 1 = volatile wiper, 2 = nonvolatile wiper, 3 = array, 4 = volatile control bits, 5 = nonvolatile control bits (block-lock), 6 and 7 reserved.

Top module: `write_permit_gate`

## Requirements
- R1: Every request other than the latch command (kind 0) is denied while the write-enable latch is clear.
- R2: Control-register requests (kinds 4 and 5) are also denied while the register-write-enable latch is clear.
- R3: While the synchronised write-protect level is high, kinds 2, 3 and 5 are denied. `wp_pin` passes through two flip-flops that reset to 1, so a request accepted at an edge sees the pin value sampled two edges earlier.
- R4: A volatile wiper request (kind 1) is granted only when the write-enable latch is set and both lock bits are 0, whatever the write-protect level.
- R5: A nonvolatile wiper request (kind 2) is granted only when the write-enable latch is set, both lock bits are 0 and write-protect is low.
- R6: An array request (kind 3) with write-protect low and write-enable set is granted unless its address is locked. Lock 00 locks nothing; 01 locks addresses whose two top bits are 11; 10 locks addresses whose top bit is 1; 11 locks all addresses.
- R7: `nv_start_o` pulses with `grant_o` for kinds 2, 3 and 5 only when `frame_ok` was high with the request. A granted kind 5 request without `frame_ok` is discarded: no start, and the lock bits and latches are unchanged.
- R8: Reset clears both latches. The latch command is always granted. `req_data[0]` loads write-enable. Register-write-enable becomes 1 only when `req_data[1:0]` is 11 and write-enable was already set; otherwise it becomes 0.
- R9: A granted kind 4 request clears register-write-enable. A granted kind 5 request with `frame_ok` loads the lock bits from `req_data[1:0]` and clears register-write-enable.
- R10: A denied request gives a single-cycle `deny_o` pulse and leaves latches and lock bits unchanged. Kinds 6 and 7 are always denied.
- R11: Volatile control-register requests (kind 4) ignore the write-protect level.
- R12: `req_ready` is always high, and each accepted request yields exactly one of `grant_o`/`deny_o` on the following cycle, including back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; the block never stalls |
| req_kind | input | 3 | Target class (encoding above) |
| req_addr | input | AW | Array address for kind 3 |
| req_data | input | 2 | Latch bits for kind 0, new lock bits for kind 5 |
| frame_ok | input | 1 | Serial frame had the correct clock count and bit sequence |
| wp_pin | input | 1 | Asynchronous write-protect pin, high = protect |
| grant_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| nv_start_o | output | 1 | Start a nonvolatile write cycle |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |
| lock_o | output | 2 | Block-lock bits |

## Verification
The assertions assume that `req_kind`, `req_addr`, `req_data` and `frame_ok` are stable across the edge at which `req_valid` is sampled. They also assume that the write-protect pin reaches the decision only through its synchroniser. The bench drives all inputs, including `wp_pin`, half a cycle away from the active edge, so every value is settled before the edge. Its reference model delays the pin by two edges, the same as the synchroniser. Directed sequences walk each lock encoding across its region boundaries and toggle write-protect while requests are in flight. A long stretch of back-to-back pseudo-random requests then mixes all kinds with random frame validity.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    K_LATCH   = 3'd0,
    K_VWIPER  = 3'd1,
    K_NVWIPER = 3'd2,
    K_ARRAY   = 3'd3,
    K_CTRL_V  = 3'd4,
    K_CTRL_NV = 3'd5
  } req_kind_e;

  localparam int KIND_W = 3;
  localparam int LOCK_W = 2;

  function automatic logic kind_is_nv(input logic [KIND_W-1:0] k);
    return (k == K_NVWIPER) || (k == K_ARRAY) || (k == K_CTRL_NV);
  endfunction
endpackage

// File: rtl/wpg_sync.sv
module wpg_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]               addr,
  input  logic [wpg_pkg::LOCK_W-1:0]  lock,
  output logic                        locked
);
  localparam int TOP = AW - 1;

  always_comb begin
    unique case (lock)
      2'b00:   locked = 1'b0;
      2'b01:   locked = addr[TOP] & addr[TOP-1];
      2'b10:   locked = addr[TOP];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_matrix.sv
module wpg_matrix
  import wpg_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              wel,
  input  logic              rwel,
  input  logic              wp,
  input  logic [LOCK_W-1:0] lock,
  input  logic              addr_locked,
  output logic              permit
);
  logic unlocked;
  assign unlocked = (lock == '0);

  always_comb begin
    unique case (kind)
      K_LATCH:   permit = 1'b1;
      K_VWIPER:  permit = wel & unlocked;
      K_NVWIPER: permit = wel & unlocked & ~wp;
      K_ARRAY:   permit = wel & ~wp & ~addr_locked;
      K_CTRL_V:  permit = wel & rwel;
      K_CTRL_NV: permit = wel & rwel & ~wp;
      default:   permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/write_permit_gate.sv
module write_permit_gate
  import wpg_pkg::*;
#(
  parameter int AW = 8,
  parameter int WP_STAGES = 2,
  parameter logic [1:0] LOCK_INIT = 2'b00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_data,
  input  logic          frame_ok,
  input  logic          wp_pin,
  output logic          grant_o,
  output logic          deny_o,
  output logic          nv_start_o,
  output logic          wel_o,
  output logic          rwel_o,
  output logic [1:0]    lock_o
);
  logic              wp_s;
  logic              addr_locked;
  logic              permit;
  logic              wel_q, rwel_q;
  logic [LOCK_W-1:0] lock_q;
  logic              grant_q, deny_q, nvst_q;
  logic              take;

  assign req_ready = 1'b1;

  wpg_sync #(.STAGES(WP_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(wp_pin), .d_out(wp_s)
  );

  wpg_region #(.AW(AW)) u_region (
    .addr(req_addr), .lock(lock_q), .locked(addr_locked)
  );

  wpg_matrix u_matrix (
    .kind(req_kind), .wel(wel_q), .rwel(rwel_q), .wp(wp_s),
    .lock(lock_q), .addr_locked(addr_locked), .permit(permit)
  );

  assign take = req_valid & permit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      rwel_q  <= 1'b0;
      lock_q  <= LOCK_INIT;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      nvst_q  <= 1'b0;
    end else begin
      grant_q <= take;
      deny_q  <= req_valid & ~permit;
      nvst_q  <= take & kind_is_nv(req_kind) & frame_ok;
      if (take) begin
        case (req_kind)
          K_LATCH: begin
            wel_q  <= req_data[0];
            rwel_q <= req_data[0] & req_data[1] & wel_q;
          end
          K_CTRL_V: rwel_q <= 1'b0;
          K_CTRL_NV: begin
            if (frame_ok) begin
              lock_q <= req_data;
              rwel_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign grant_o    = grant_q;
  assign deny_o     = deny_q;
  assign nv_start_o = nvst_q;
  assign wel_o      = wel_q;
  assign rwel_o     = rwel_q;
  assign lock_o     = lock_q;

  AST_NO_WRITE_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 3'd0 && !wel_o) |=> deny_o) else $error("wel"); // R1
  AST_CTRL_NEEDS_RWEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd4 || req_kind == 3'd5) && !rwel_o) |=> deny_o) else $error("rwel"); // R2
  AST_WP_BLOCKS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wp_s && (req_kind == 3'd2 || req_kind == 3'd3 || req_kind == 3'd5)) |=> (!grant_o && !nv_start_o)) else $error("wp"); // R3
  AST_START_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !frame_ok) |=> !nv_start_o) else $error("frame"); // R7
  AST_START_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start_o |-> grant_o) else $error("start"); // R7
  AST_DENY_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |-> ($stable(wel_o) && $stable(rwel_o) && $stable(lock_o))) else $error("deny"); // R10
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $onehot({grant_o, deny_o})) else $error("answer"); // R12
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant_o || deny_o)) else $error("spurious"); // R12
endmodule

// File: tb/write_permit_gate_test.sv
module write_permit_gate_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_data = '0;
  logic frame_ok = 1'b0;
  logic wp_pin = 1'b0;
  logic grant_o, deny_o, nv_start_o, wel_o, rwel_o;
  logic [1:0] lock_o;

  int checks = 0;
  int errors = 0;
  string tag = "R12";
  string exp_tag = "R12";
  bit finished = 0;

  // reference model state
  int m_wel, m_rwel, m_lock, m_wp1, m_wp2;
  int e_grant, e_deny, e_start;

  always #2 clk = ~clk;

  write_permit_gate #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .frame_ok(frame_ok), .wp_pin(wp_pin), .grant_o(grant_o), .deny_o(deny_o),
    .nv_start_o(nv_start_o), .wel_o(wel_o), .rwel_o(rwel_o), .lock_o(lock_o)
  );

  function automatic int region_locked(int lk, int a);
    if (lk == 0) return 0;
    if (lk == 1) return (a >= 192) ? 1 : 0;
    if (lk == 2) return (a >= 128) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    int ok, k, wpv;
    if (!rst_n) begin
      m_wel = 0; m_rwel = 0; m_lock = 0; m_wp1 = 1; m_wp2 = 1;
      e_grant = 0; e_deny = 0; e_start = 0;
    end else begin
      wpv = m_wp2;
      k = req_kind;
      e_grant = 0; e_deny = 0; e_start = 0;
      exp_tag = tag;
      if (req_valid) begin
        if (k == 0) ok = 1;
        else if (k == 1) ok = m_wel && m_lock == 0;
        else if (k == 2) ok = m_wel && m_lock == 0 && !wpv;
        else if (k == 3) ok = m_wel && !wpv && !region_locked(m_lock, req_addr);
        else if (k == 4) ok = m_wel && m_rwel;
        else if (k == 5) ok = m_wel && m_rwel && !wpv;
        else ok = 0;
        e_grant = ok; e_deny = !ok;
        e_start = ok && (k == 2 || k == 3 || k == 5) && frame_ok;
        if (ok) begin
          if (k == 0) begin
            m_rwel = (req_data == 2'b11 && m_wel) ? 1 : 0;
            m_wel = req_data[0];
          end else if (k == 4) m_rwel = 0;
          else if (k == 5 && frame_ok) begin
            m_lock = req_data; m_rwel = 0;
          end
        end
      end
      m_wp2 = m_wp1; m_wp1 = wp_pin;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(exp_tag, "grant", grant_o, e_grant);
      chk(exp_tag, "deny", deny_o, e_deny);
      chk(exp_tag, "nv_start", nv_start_o, e_start);
      chk(exp_tag, "wel", wel_o, m_wel);
      chk(exp_tag, "rwel", rwel_o, m_rwel);
      chk(exp_tag, "lock", lock_o, m_lock);
      chk("R12", "ready", req_ready, 1);
    end
  end

  task automatic send(string t, int k, int a, int d, int f);
    @(negedge clk);
    tag = t;
    req_valid = 1'b1; req_kind = k[2:0]; req_addr = a[AW-1:0];
    req_data = d[1:0]; frame_ok = f[0];
    @(negedge clk);
    req_valid = 1'b0; frame_ok = 1'b0;
  endtask

  task automatic set_wp(int v);
    @(negedge clk);
    wp_pin = v[0];
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", "reset wel", wel_o, 0);
    chk("R8", "reset rwel", rwel_o, 0);
    set_wp(0);
    send("R1", 1, 0, 0, 1);
    send("R1", 3, 5, 0, 1);
    send("R1", 4, 0, 0, 1);
    send("R8", 0, 0, 2'b10, 0);   // rwel request without wel
    send("R8", 0, 0, 2'b11, 0);   // sets wel only
    send("R2", 4, 0, 0, 1);       // no rwel
    send("R8", 0, 0, 2'b11, 0);   // now rwel
    set_wp(1);
    send("R11", 4, 0, 0, 1);      // volatile ctrl with wp high
    send("R9", 0, 0, 2'b11, 0);
    send("R3", 2, 0, 0, 1);
    send("R3", 3, 10, 0, 1);
    send("R3", 5, 0, 2'b01, 1);
    send("R4", 1, 0, 0, 1);
    set_wp(0);
    send("R7", 5, 0, 2'b01, 0);   // discarded: no frame
    send("R9", 5, 0, 2'b01, 1);   // lock 01
    send("R6", 3, 8'hC0, 0, 1);
    send("R6", 3, 8'hBF, 0, 1);
    send("R4", 1, 0, 0, 1);
    send("R5", 2, 0, 0, 1);
    send("R2", 5, 0, 2'b10, 1);   // rwel cleared
    send("R8", 0, 0, 2'b11, 0);
    send("R9", 5, 0, 2'b10, 1);   // lock 10
    send("R6", 3, 8'h80, 0, 1);
    send("R6", 3, 8'h7F, 0, 1);
    send("R8", 0, 0, 2'b11, 0);
    send("R9", 5, 0, 2'b11, 1);   // lock 11
    send("R6", 3, 0, 0, 1);
    send("R8", 0, 0, 2'b11, 0);
    send("R9", 5, 0, 2'b00, 1);   // unlock
    send("R6", 3, 8'hFF, 0, 1);
    send("R5", 2, 0, 0, 1);
    send("R7", 2, 0, 0, 0);
    send("R7", 3, 3, 0, 0);
    send("R10", 6, 0, 0, 1);
    send("R10", 7, 0, 0, 1);
    // R12 back-to-back pseudo-random traffic with wp toggling
    @(negedge clk);
    tag = "R12";
    for (int i = 0; i < 2000; i++) begin
      req_valid = ($urandom_range(0, 3) != 0);
      req_kind = 3'($urandom_range(0, 7));
      req_addr = AW'($urandom);
      req_data = 2'($urandom);
      frame_ok = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) wp_pin = ~wp_pin;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule